// File: doc/BRIEF.md
# Scannable hysteresis threshold gate

This block is an m-of-n threshold operator with hysteresis for self-timed dual-rail datapaths. Its output rises once enough inputs are high, then stays high until all inputs have returned low. Between those two events the output holds its value. The held value lives in an explicit storage cell rather than in a hidden loop. That cell joins the chip's scan chain during test, so the hold term can be loaded and read back by a tester.

The storage cell is a clocked flop. In functional mode it samples the gate output on every clock edge and feeds it back as the previous output. This is the clocked equivalent of a transparent feedback buffer, provided the inputs change at most once per cycle. In test mode with shift enabled, the cell loads the serial scan input instead. In test mode with shift disabled, it captures the freshly computed output, which makes a stuck feedback value observable.

When the threshold is 1 the gate is a plain OR. No storage is built in that case, and the scan path passes straight through.

Top module: `th_scan_gate`

## Requirements
- R1: With M_TH > 1, `z_o` is 1 whenever at least M_TH bits of `in_i` are 1, whatever the held state.
- R2: `z_o` is 0 whenever every bit of `in_i` is 0, whatever the held state.
- R3: With M_TH > 1 and between 1 and M_TH-1 inputs high, `z_o` equals the held state. Each clock edge with `test_mode_i`=0, or with `test_mode_i`=1 and `scan_en_i`=0, sets the held state to the `z_o` value present just before that edge.
- R4: While `rst_ni` is 0, the held state is cleared to 0 asynchronously.
- R5: With M_TH > 1, a clock edge with `test_mode_i`=1 and `scan_en_i`=1 loads `scan_i` into the held state, and that loaded value then acts as the hold term of R3.
- R6: With M_TH > 1, `scan_o` equals the held state while `test_mode_i`=1 and is 0 while `test_mode_i`=0.
- R7: With M_TH > 1 and `test_mode_i`=0, `scan_en_i` and `scan_i` have no effect: the held state keeps following R3.
- R8: With M_TH = 1, `z_o` is the OR of `in_i` with no state, and `scan_o` equals `scan_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the feedback storage cell |
| rst_ni | input | 1 | Active-low asynchronous reset of the held state |
| test_mode_i | input | 1 | 1 selects test mode |
| scan_en_i | input | 1 | In test mode, 1 shifts and 0 captures |
| scan_i | input | 1 | Serial scan input |
| in_i | input | N_IN | Threshold gate inputs |
| z_o | output | 1 | Gate output |
| scan_o | output | 1 | Serial scan output |

## Verification
The bench builds two instances on shared inputs. The first is the 2-of-3 gate. The second is a 1-of-3 gate that checks the OR reduction and the scan pass-through.

With three inputs, every ordered pair of input patterns can be swept in both functional and test modes. The sweep therefore reaches each set, hold and release transition from both held values. Scan loading of 0 and 1 under a single high input exposes the hold term directly, because in that case the output has no other source.

// File: rtl/th_gate_pkg.sv
package th_gate_pkg;
  typedef enum logic [1:0] {
    FB_CAPTURE = 2'b00,
    FB_SHIFT   = 2'b01
  } fb_op_e;
endpackage

// File: rtl/th_set_logic.sv
module th_set_logic #(
  parameter int N_IN = 3,
  parameter int M_TH = 2
) (
  input  logic [N_IN-1:0] in_i,
  output logic            set_o,
  output logic            any_o
);
  localparam int CW = $clog2(N_IN + 1);
  localparam logic [CW-1:0] THR = CW'(M_TH);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < N_IN; k++) cnt = cnt + CW'(in_i[k]);
  end

  assign set_o = (cnt >= THR);
  assign any_o = |in_i;
endmodule

// File: rtl/th_fb_cell.sv
module th_fb_cell
  import th_gate_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  fb_op_e op_i,
  input  logic   d_i,
  input  logic   scan_i,
  output logic   q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else if (op_i == FB_SHIFT) q_o <= scan_i;
    else q_o <= d_i;
  end
endmodule

// File: rtl/th_scan_gate.sv
module th_scan_gate
  import th_gate_pkg::*;
#(
  parameter int N_IN = 3,
  parameter int M_TH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            test_mode_i,
  input  logic            scan_en_i,
  input  logic            scan_i,
  input  logic [N_IN-1:0] in_i,
  output logic            z_o,
  output logic            scan_o
);
  logic set_w, any_w;

  th_set_logic #(.N_IN(N_IN), .M_TH(M_TH)) set_i (
    .in_i (in_i),
    .set_o(set_w),
    .any_o(any_w)
  );

  generate
    if (M_TH == 1) begin : g_or
      // hysteresis is redundant: no storage, scan path bypasses the gate
      assign z_o    = any_w;
      assign scan_o = scan_i;
    end else begin : g_hyst
      fb_op_e op_w;
      logic   held_q;

      assign op_w = (test_mode_i && scan_en_i) ? FB_SHIFT : FB_CAPTURE;

      th_fb_cell fb_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .op_i  (op_w),
        .d_i   (z_o),
        .scan_i(scan_i),
        .q_o   (held_q)
      );

      assign z_o    = set_w | (any_w & held_q);
      assign scan_o = test_mode_i & held_q;
    end
  endgenerate
endmodule

// File: rtl/th_scan_gate_chk.sv
module th_scan_gate_chk #(
  parameter int N_IN = 3,
  parameter int M_TH = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            test_mode_i,
  input logic            scan_en_i,
  input logic            scan_i,
  input logic [N_IN-1:0] in_i,
  input logic            z_o,
  input logic            scan_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  AST_ALL_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_i == '0) |-> !z_o); // R2

  generate
    if (M_TH == 1) begin : g_or_chk
      AST_OR_REDUCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        z_o == (|in_i)); // R8
      AST_SCAN_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_o == scan_i); // R8
    end else begin : g_hyst_chk
      AST_SET_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(in_i) >= M_TH) |-> z_o); // R1
      AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(!(test_mode_i && scan_en_i)) && $past(z_o) && (|in_i)) |-> z_o); // R3
      AST_SHIFT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(test_mode_i && scan_en_i) && test_mode_i) |-> (scan_o == $past(scan_i))); // R5
      AST_SCAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_mode_i |-> !scan_o); // R6
    end
  endgenerate
endmodule

bind th_scan_gate th_scan_gate_chk #(.N_IN(N_IN), .M_TH(M_TH)) chk_i (.*);

// File: tb/th_scan_gate_tb_top.sv
module th_scan_gate_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       test_mode_i = 1'b0;
  logic       scan_en_i = 1'b0;
  logic       scan_i = 1'b0;
  logic [2:0] in_i = 3'b000;
  logic       z_o, scan_o, z1_o, so1_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic ref_q = 1'b0;
  bit done = 1'b0;

  always #2.5ns clk_i = ~clk_i;

  th_scan_gate #(.N_IN(3), .M_TH(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_mode_i(test_mode_i), .scan_en_i(scan_en_i),
    .scan_i(scan_i), .in_i(in_i), .z_o(z_o), .scan_o(scan_o)
  );

  th_scan_gate #(.N_IN(3), .M_TH(1)) dut_or_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_mode_i(test_mode_i), .scan_en_i(scan_en_i),
    .scan_i(scan_i), .in_i(in_i), .z_o(z1_o), .scan_o(so1_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] v, input logic tm, input logic se, input logic si);
    logic zexp;
    int   ones;
    @(negedge clk_i);
    in_i = v; test_mode_i = tm; scan_en_i = se; scan_i = si;
    #1ns;
    ones = $countones(v);
    zexp = (ones >= 2) | ((|v) & ref_q);
    if (ones >= 2)      chk("R1 set", z_o, zexp);
    else if (ones == 0) chk("R2 release", z_o, zexp);
    else if (!tm && se) chk("R7 scan ignored in functional mode", z_o, zexp);
    else if (tm)        chk("R5 held value drives hold term", z_o, zexp);
    else                chk("R3 hold", z_o, zexp);
    chk("R6 scan_o", scan_o, tm ? ref_q : 1'b0);
    chk("R8 or output", z1_o, |v);
    chk("R8 scan bypass", so1_o, si);
    @(posedge clk_i);
    ref_q = (tm && se) ? si : zexp;
  endtask

  initial begin
    #1000000ns;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state
    #3ns;
    chk("R4 reset z", z_o, 1'b0);
    chk("R4 reset scan_o", scan_o, 1'b0);
    in_i = 3'b001; #1ns;
    chk("R4 reset hold clear", z_o, 1'b0);
    in_i = 3'b000;
    @(negedge clk_i); rst_ni = 1'b1;
    ref_q = 1'b0;

    // functional: all ordered pairs of patterns
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        step(3'(a), 1'b0, 1'b0, 1'b0);
        step(3'(b), 1'b0, 1'b0, 1'b0);
      end

    // functional with scan_en asserted and scan_i toggling: ignored (R7)
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        step(3'(a), 1'b0, 1'b1, ~z_o);
        step(3'(b), 1'b0, 1'b1, 1'(b));
      end

    // test mode shift: load value, then observe through hold term and scan_o (R5, R6)
    for (int k = 0; k < 16; k++) begin
      step(3'b010, 1'b1, 1'b1, 1'(k % 3 == 0));
      step(3'b100, 1'b1, 1'b1, 1'(k % 2));
      step(3'b000, 1'b1, 1'b1, 1'b1);
    end

    // test mode capture: all ordered pairs (R3 in test mode)
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        step(3'(a), 1'b1, 1'b0, 1'b1);
        step(3'(b), 1'b1, 1'b0, 1'b0);
      end

    // capture then shift out
    step(3'b011, 1'b1, 1'b0, 1'b0);
    step(3'b001, 1'b1, 1'b1, 1'b0);
    step(3'b001, 1'b1, 1'b1, 1'b0);

    // asynchronous reset clears a loaded 1 (R4)
    step(3'b001, 1'b1, 1'b1, 1'b1);
    step(3'b001, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0; in_i = 3'b001; test_mode_i = 1'b1;
    #1ns;
    chk("R4 async clear z", z_o, 1'b0);
    chk("R4 async clear scan_o", scan_o, 1'b0);
    ref_q = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    step(3'b001, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule